// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block sends multi-slot time-division-multiplexed audio frames on one serial data line. It generates the bit clock and the frame sync from a half-bit timing strobe that an external divider supplies. Parallel sample words arrive over a valid/ready handshake. Each enabled slot takes one word and shifts it out most-significant bit first. Slots that are disabled send zeros and take no word.

Software sets up the frame through a small write-only register port. The settings are slot count, slot width, word width, a 32-bit slot mask written as two 16-bit halves, frame-sync shape and position, the polarity of both clocks, word alignment, and network versus single-slot (mono) mode. When the enable bit is set, the block sends one lead-in bit and then frames continuously until the enable bit is cleared. A missing word at the start of an enabled slot is sent as zeros and sets a sticky underrun flag. A one-cycle pulse marks the start of the last slot of each frame.

Top module: `tdm_frame_tx`

## Requirements
- R1: After reset the block is idle with sdOut=0, fsOut=0, bclkOut=1, wordReady=0, lastSlot=0 and underrun=0. The default frame is 2 slots of 32 bits with 24-bit words, network mode, all 32 slots enabled, left alignment, a one-bit frame sync aligned with the first bit, and no inversion.
- R2: The register port takes one write per cycle with cfgWe high. The addresses are:
  - Address 0 (control): bit0 enable, bit1 network, bit2 word-length sync, bit3 early sync, bit4 sync invert, bit5 bit-clock polarity, bit6 right align, bit7 clear underrun (write-one).
  - Address 1 (format): bits[4:0] slots minus 1, bits[9:5] slot width minus 1, bits[11:10] word width code (0=8, 1=16, 2=20, 3=24 bits).
  - Address 2: mask bits 15..0.
  - Address 3: mask bits 31..16.
- R3: While running, every second halfTick is a launch. At a launch sdOut and fsOut take their new values and bclkOut goes to the level of the polarity bit. The next halfTick returns bclkOut to the opposite level, which is the sampling edge. With halfTick low, sdOut, fsOut and bclkOut stay unchanged.
- R4: After enable, the first launched bit is a lead-in bit carrying data 0. It is followed by frames of slot 0 up to the last slot, each slot sending its bits most-significant bit first.
- R5: Counting frame bits g from 0, with frame length L and active length len (the slot width for a word-length sync, 1 otherwise):
  - An aligned sync is active when g < len.
  - An early sync is active when (g+1) mod L < len; the lead-in bit counts as g = L-1.
  - fsOut is the active value XOR the invert bit.
- R6: A word occupies the selected number of low bits of sampleIn. Left alignment puts its MSB on the first slot bit. Right alignment puts its LSB on the last slot bit. All other slot bits are 0.
- R7: A slot whose mask bit is 0 sends only zeros and takes no word. Both mask halves are honoured.
- R8: With network mode off, only slot 0 (if its mask bit is set) carries data and takes a word. Every other slot sends zeros.
- R9: When an enabled data slot starts with wordValid low, the slot sends zeros and underrun goes to 1. Underrun stays 1 until a control write with bit7 set clears it.
- R10: lastSlot pulses high for one cycle at the launch of the first bit of the last slot of each frame, and never for the lead-in bit.
- R11: wordReady is high for exactly one cycle, at the launch of the first bit of each data-carrying slot. The word is taken when wordValid is also high, so words are consumed in slot order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address |
| cfgWdata | input | 16 | Register write data |
| halfTick | input | 1 | Half-bit-period timing strobe |
| sampleIn | input | 24 | Sample word, right-justified |
| wordValid | input | 1 | Sample word valid |
| wordReady | output | 1 | Sample word accepted this cycle |
| sdOut | output | 1 | Serial data |
| fsOut | output | 1 | Frame sync |
| bclkOut | output | 1 | Bit clock |
| lastSlot | output | 1 | Pulse at start of last slot |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench records every launched bit at the bit-clock launch edge and compares each one with a stream computed from the requirements. It covers the three sync shapes, both clock polarities, right alignment with a word narrower than the slot, and a mask that lives only in the upper half. A design that placed the early sync one bit late, or let a disabled slot take a word, would shift every later sample in the stream. Mono mode is checked with four slots, where a design that ignored the mode bit would put data into slots 1 to 3. A halfTick stall in the middle of a frame catches outputs that move without a strobe. The underrun test catches a flag that clears itself, or one that sets while words are present.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int MAX_SLOTS   = 32;
  localparam int MAX_SLOT_W  = 32;
  localparam int SAMPLE_W    = 24;
  localparam int CFG_DATA_W  = 16;
  localparam int CFG_ADDR_W  = 2;
  localparam int SLOT_CNT_W  = $clog2(MAX_SLOTS);
  localparam int BIT_CNT_W   = $clog2(MAX_SLOT_W);
  localparam int WW_BITS_W   = $clog2(SAMPLE_W) + 1;
  localparam int PAD_W       = MAX_SLOT_W - SAMPLE_W;

  localparam logic [CFG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [CFG_ADDR_W-1:0] ADDR_FMT  = 2'd1;
  localparam logic [CFG_ADDR_W-1:0] ADDR_MLO  = 2'd2;
  localparam logic [CFG_ADDR_W-1:0] ADDR_MHI  = 2'd3;

  localparam int CB_EN    = 0;
  localparam int CB_NET   = 1;
  localparam int CB_FSW   = 2;
  localparam int CB_EARLY = 3;
  localparam int CB_FSINV = 4;
  localparam int CB_CKPOL = 5;
  localparam int CB_RIGHT = 6;
  localparam int CB_CLR   = 7;

  typedef enum logic [1:0] {
    WW8  = 2'd0,
    WW16 = 2'd1,
    WW20 = 2'd2,
    WW24 = 2'd3
  } wordWidth_e;

  typedef struct packed {
    logic launch;
    logic load;
    logic slotOn;
    logic idle;
  } txStrobe_t;
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [CFG_ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_DATA_W-1:0]  cfgWdata,
  input  logic                   halfTick,
  input  logic                   wordValid,
  output logic                   wordReady,
  output logic                   fsOut,
  output logic                   bclkOut,
  output logic                   lastSlot,
  output logic                   underrun,
  output logic                   rightAlign,
  output logic [BIT_CNT_W-1:0]   lastBit,
  output wordWidth_e             wordWidth,
  output txStrobe_t              strb
);
  localparam int HALF_W = CFG_DATA_W;

  logic enableQ, networkQ, fsWordQ, fsEarlyQ, fsInvQ, ckPolQ, rightQ;
  logic [SLOT_CNT_W-1:0] lastSlotQ;
  logic [BIT_CNT_W-1:0]  lastBitQ;
  wordWidth_e            wwQ;
  logic [MAX_SLOTS-1:0]  maskQ;

  logic                  running, phase, leadIn;
  logic [SLOT_CNT_W-1:0] slotQ;
  logic [BIT_CNT_W-1:0]  bitQ;
  logic                  fsQ, lastQ, underrunQ;

  logic launch, load, slotOn, clrReq, isLastPos, fsAct;

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      networkQ  <= 1'b1;
      fsWordQ   <= 1'b0;
      fsEarlyQ  <= 1'b0;
      fsInvQ    <= 1'b0;
      ckPolQ    <= 1'b0;
      rightQ    <= 1'b0;
      lastSlotQ <= SLOT_CNT_W'(1);
      lastBitQ  <= BIT_CNT_W'(MAX_SLOT_W - 1);
      wwQ       <= WW24;
      maskQ     <= '1;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_CTRL: begin
          enableQ  <= cfgWdata[CB_EN];
          networkQ <= cfgWdata[CB_NET];
          fsWordQ  <= cfgWdata[CB_FSW];
          fsEarlyQ <= cfgWdata[CB_EARLY];
          fsInvQ   <= cfgWdata[CB_FSINV];
          ckPolQ   <= cfgWdata[CB_CKPOL];
          rightQ   <= cfgWdata[CB_RIGHT];
        end
        ADDR_FMT: begin
          lastSlotQ <= cfgWdata[SLOT_CNT_W-1:0];
          lastBitQ  <= cfgWdata[SLOT_CNT_W +: BIT_CNT_W];
          wwQ       <= wordWidth_e'(cfgWdata[SLOT_CNT_W+BIT_CNT_W +: 2]);
        end
        ADDR_MLO: maskQ[HALF_W-1:0]         <= cfgWdata;
        default:  maskQ[MAX_SLOTS-1:HALF_W] <= cfgWdata;
      endcase
    end
  end

  assign clrReq = cfgWe && (cfgAddr == ADDR_CTRL) && cfgWdata[CB_CLR];

  // Slot/bit sequencer; position holds the bit launched next
  assign launch = running && halfTick && !phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
      leadIn  <= 1'b0;
      slotQ   <= '0;
      bitQ    <= '0;
    end else if (!enableQ) begin
      running <= 1'b0;
      phase   <= 1'b0;
    end else if (!running) begin
      running <= 1'b1;
      phase   <= 1'b0;
      leadIn  <= 1'b1;
      slotQ   <= lastSlotQ;
      bitQ    <= lastBitQ;
    end else begin
      if (halfTick) phase <= !phase;
      if (launch) begin
        leadIn <= 1'b0;
        if (bitQ == lastBitQ) begin
          bitQ  <= '0;
          slotQ <= (slotQ == lastSlotQ) ? '0 : slotQ + SLOT_CNT_W'(1);
        end else begin
          bitQ <= bitQ + BIT_CNT_W'(1);
        end
      end
    end
  end

  assign slotOn    = maskQ[slotQ] && (networkQ || (slotQ == '0));
  assign load      = launch && !leadIn && (bitQ == '0);
  assign isLastPos = (slotQ == lastSlotQ) && (bitQ == lastBitQ);

  always_comb begin
    if (fsEarlyQ)
      fsAct = isLastPos || (fsWordQ && (slotQ == '0) && (bitQ != lastBitQ));
    else
      fsAct = (slotQ == '0) && (fsWordQ || (bitQ == '0));
  end

  // Output flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsQ       <= 1'b0;
      lastQ     <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      lastQ <= load && (slotQ == lastSlotQ);
      if (!running)    fsQ <= fsInvQ;
      else if (launch) fsQ <= fsAct ^ fsInvQ;
      if (load && slotOn && !wordValid) underrunQ <= 1'b1;
      else if (clrReq)                  underrunQ <= 1'b0;
    end
  end

  assign wordReady   = load && slotOn;
  assign fsOut       = fsQ;
  assign bclkOut     = !phase ^ ckPolQ;
  assign lastSlot    = lastQ;
  assign underrun    = underrunQ;
  assign rightAlign  = rightQ;
  assign lastBit     = lastBitQ;
  assign wordWidth   = wwQ;
  assign strb.launch = launch;
  assign strb.load   = load;
  assign strb.slotOn = slotOn;
  assign strb.idle   = !running;
endmodule

// File: rtl/tdm_tx_dp.sv
module tdm_tx_dp
  import tdm_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  txStrobe_t             strb,
  input  logic                  rightAlign,
  input  logic [BIT_CNT_W-1:0]  lastBit,
  input  wordWidth_e            wordWidth,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  input  logic                  wordValid,
  output logic                  sdOut
);
  logic [WW_BITS_W-1:0]  wwN;
  logic [SAMPLE_W-1:0]   wMask, masked;
  logic [MAX_SLOT_W-1:0] image;
  logic [MAX_SLOT_W-1:0] shQ;
  logic                  sdQ;

  always_comb begin
    case (wordWidth)
      WW8:     wwN = WW_BITS_W'(8);
      WW16:    wwN = WW_BITS_W'(16);
      WW20:    wwN = WW_BITS_W'(20);
      default: wwN = WW_BITS_W'(24);
    endcase
    wMask  = SAMPLE_W'((32'd1 << wwN) - 32'd1);
    masked = sampleIn & wMask;
    if (!(strb.slotOn && wordValid))
      image = '0;
    else if (rightAlign)
      image = {{PAD_W{1'b0}}, masked} << (BIT_CNT_W'(MAX_SLOT_W - 1) - lastBit);
    else
      image = {masked, {PAD_W{1'b0}}} << (WW_BITS_W'(SAMPLE_W) - wwN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdQ <= 1'b0;
      shQ <= '0;
    end else if (strb.idle) begin
      sdQ <= 1'b0;
      shQ <= '0;
    end else if (strb.launch) begin
      if (strb.load) begin
        sdQ <= image[MAX_SLOT_W-1];
        shQ <= image << 1;
      end else begin
        sdQ <= shQ[MAX_SLOT_W-1];
        shQ <= shQ << 1;
      end
    end
  end

  assign sdOut = sdQ;
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
  import tdm_tx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [CFG_DATA_W-1:0] cfgWdata,
  input  logic                  halfTick,
  input  logic [SAMPLE_W-1:0]   sampleIn,
  input  logic                  wordValid,
  output logic                  wordReady,
  output logic                  sdOut,
  output logic                  fsOut,
  output logic                  bclkOut,
  output logic                  lastSlot,
  output logic                  underrun
);
  txStrobe_t             strb;
  logic                  rightAlign;
  logic [BIT_CNT_W-1:0]  lastBit;
  wordWidth_e            wordWidth;

  tdm_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .halfTick(halfTick), .wordValid(wordValid), .wordReady(wordReady),
    .fsOut(fsOut), .bclkOut(bclkOut), .lastSlot(lastSlot), .underrun(underrun),
    .rightAlign(rightAlign), .lastBit(lastBit), .wordWidth(wordWidth), .strb(strb)
  );

  tdm_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rightAlign(rightAlign), .lastBit(lastBit),
    .wordWidth(wordWidth), .sampleIn(sampleIn), .wordValid(wordValid), .sdOut(sdOut)
  );
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [1:0] cfgAddr,
  input logic       clrBit,
  input logic       wordValid,
  input logic       wordReady,
  input logic       sdOut,
  input logic       lastSlot,
  input logic       underrun,
  input logic       launchS,
  input logic       idleS
);
  // R11: a word is offered for one cycle only
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |=> !wordReady);

  // R9: missing word at slot start raises the flag
  p_underrun_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && !wordValid) |=> underrun);

  // R9: the flag holds until a clearing write
  p_underrun_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !(cfgWe && cfgAddr == 2'd0 && clrBit)) |=> underrun);

  // R10: last-slot mark is a single-cycle pulse
  p_last_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    lastSlot |=> !lastSlot);

  // R3: serial data moves only at a launch
  p_sd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!launchS && !idleS) |=> $stable(sdOut));
endmodule

bind tdm_frame_tx tdm_frame_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .clrBit(cfgWdata[7]),
  .wordValid(wordValid), .wordReady(wordReady), .sdOut(sdOut), .lastSlot(lastSlot),
  .underrun(underrun), .launchS(strb.launch), .idleS(strb.idle)
);

// File: tb/sim_tdm_frame_tx.sv
`timescale 1ns/1ps
module sim_tdm_frame_tx;
  localparam int RING = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [15:0] cfgWdata = 16'd0;
  logic        halfTick = 1'b1;
  logic        srcOn = 1'b1;
  logic [23:0] sampleIn;
  logic        wordReady, sdOut, fsOut, bclkOut, lastSlot, underrun;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // bench view of the configuration
  int bSlots = 2, bSlotW = 32, bWw = 24;
  bit bNet = 1, bFsWord = 0, bEarly = 0, bInv = 0, bCkPol = 0, bRight = 0;
  logic [31:0] bMask = 32'hFFFF_FFFF;

  int takes = 0;
  bit pend = 0;
  bit recSd[RING];
  bit recFs[RING];
  bit recLast[RING];
  int recCount = 0;
  logic prevBclk = 1'b1;

  function automatic logic [23:0] wordOf(int k);
    logic [31:0] t;
    t = k * 32'h0019_660D + 32'h3C6E_F35F;
    return t[27:4];
  endfunction

  assign sampleIn = wordOf(takes);

  tdm_frame_tx u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .halfTick(halfTick), .sampleIn(sampleIn), .wordValid(srcOn), .wordReady(wordReady),
    .sdOut(sdOut), .fsOut(fsOut), .bclkOut(bclkOut), .lastSlot(lastSlot), .underrun(underrun)
  );

  always #2.5 clk = ~clk;

  // observer: counts handshakes and records each launched bit
  always @(negedge clk) begin
    if (pend) takes = takes + 1;
    pend = wordReady && srcOn;
    if (rstN && bclkOut !== prevBclk && bclkOut == bCkPol) begin
      recSd[recCount % RING]   = sdOut;
      recFs[recCount % RING]   = fsOut;
      recLast[recCount % RING] = lastSlot;
      recCount = recCount + 1;
    end
    prevBclk = bclkOut;
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic logic [15:0] ctrlWord(bit en, bit clr);
    return 16'(en) | (16'(bNet) << 1) | (16'(bFsWord) << 2) | (16'(bEarly) << 3) |
           (16'(bInv) << 4) | (16'(bCkPol) << 5) | (16'(bRight) << 6) | (16'(clr) << 7);
  endfunction

  task automatic applyCfg();
    int code;
    code = (bWw == 8) ? 0 : (bWw == 16) ? 1 : (bWw == 20) ? 2 : 3;
    wr(2'd1, 16'((bSlots - 1) | ((bSlotW - 1) << 5) | (code << 10)));
    wr(2'd2, bMask[15:0]);
    wr(2'd3, bMask[31:16]);
    wr(2'd0, ctrlWord(0, 0));
  endtask

  function automatic bit slotCarries(int s);
    return bMask[s] && (bNet || s == 0);
  endfunction

  function automatic logic [31:0] imgOf(logic [23:0] w);
    logic [31:0] m;
    m = {8'd0, w} & ((32'd1 << bWw) - 32'd1);
    if (bRight) return m << (32 - bSlotW);
    return m << (32 - bWw);
  endfunction

  function automatic bit fsExp(int g);
    int flen, frame;
    flen  = bFsWord ? bSlotW : 1;
    frame = bSlots * bSlotW;
    if (bEarly) return ((((g + 1) % frame) < flen) ? 1'b1 : 1'b0) ^ bInv;
    return ((g < flen) ? 1'b1 : 1'b0) ^ bInv;
  endfunction

  // start, optionally stall mid-run, stop, then compare the whole recorded stream
  task automatic runCheck(string reqSd, string reqFs, int nFrames, bit stall);
    int frame, need, base, tBase, perFrame, guard;
    frame = bSlots * bSlotW;
    need  = 1 + nFrames * frame;
    base  = recCount;
    tBase = takes;
    perFrame = 0;
    for (int s = 0; s < bSlots; s++) if (slotCarries(s)) perFrame++;
    wr(2'd0, ctrlWord(1, 0));
    if (stall) begin
      guard = 0;
      while (recCount - base < 40 && guard < 20000) begin @(negedge clk); guard++; end
      halfTick = 1'b0;
      begin
        logic sd0, fs0, bk0;
        sd0 = sdOut; fs0 = fsOut; bk0 = bclkOut;
        repeat (6) begin
          @(negedge clk);
          check("R3", "stall sdOut", sdOut, sd0);
          check("R3", "stall fsOut", fsOut, fs0);
          check("R3", "stall bclkOut", bclkOut, bk0);
        end
      end
      halfTick = 1'b1;
    end
    guard = 0;
    while (recCount - base < need && guard < 50000) begin @(negedge clk); guard++; end
    wr(2'd0, ctrlWord(0, 0));
    repeat (4) @(negedge clk);
    if (recCount - base < need) begin
      check(reqSd, "bits recorded", recCount - base, need);
      return;
    end
    for (int i = 0; i < need; i++) begin
      int idx, g, f, w, s, b, k;
      bit eSd, eFs, eLast;
      idx = (base + i) % RING;
      if (i == 0) begin
        eSd = 0; eFs = fsExp(frame - 1); eLast = 0;   // R4 lead-in bit
      end else begin
        g = i - 1; f = g / frame; w = g % frame; s = w / bSlotW; b = w % bSlotW;
        k = f * perFrame;
        for (int t = 0; t < s; t++) if (slotCarries(t)) k++;
        if (slotCarries(s) && srcOn) begin
          logic [31:0] im;
          im = imgOf(wordOf(tBase + k));
          eSd = im[31 - b];
        end else eSd = 0;
        eFs   = fsExp(w);
        eLast = (b == 0 && s == bSlots - 1);
      end
      check(reqSd, $sformatf("sdOut bit %0d", i), recSd[idx], eSd);
      check(reqFs, $sformatf("fsOut bit %0d", i), recFs[idx], eFs);
      check("R10", $sformatf("lastSlot bit %0d", i), recLast[idx], eLast);
    end
  endtask

  task automatic setFmt(int slots, int slotW, int ww, bit net, logic [31:0] mask);
    bSlots = slots; bSlotW = slotW; bWw = ww; bNet = net; bMask = mask;
  endtask

  task automatic setSync(bit fw, bit early, bit inv, bit ckp, bit right);
    bFsWord = fw; bEarly = early; bInv = inv; bCkPol = ckp; bRight = right;
  endtask

  task automatic testReset();
    check("R1", "reset sdOut", sdOut, 0);
    check("R1", "reset fsOut", fsOut, 0);
    check("R1", "reset bclkOut", bclkOut, 1);
    check("R1", "reset wordReady", wordReady, 0);
    check("R1", "reset lastSlot", lastSlot, 0);
    check("R1", "reset underrun", underrun, 0);
  endtask

  task automatic testDefaults();
    // R1 defaults, R4 MSB-first order, R11 in-order consumption, no config writes
    runCheck("R1", "R5", 3, 0);
  endtask

  task automatic testWordSync();
    // R5 word-length early inverted sync, R2 format decode, R3 stall
    setFmt(2, 32, 16, 1, 32'hFFFF_FFFF);
    setSync(1, 1, 1, 0, 0);
    applyCfg();
    runCheck("R6", "R5", 3, 1);
  endtask

  task automatic testOneBitEarly();
    // R5 one-bit early sync, R7 disabled slot 2 pads and takes nothing
    setFmt(4, 16, 16, 1, 32'h0000_000B);
    setSync(0, 1, 0, 0, 0);
    applyCfg();
    runCheck("R7", "R5", 3, 0);
  endtask

  task automatic testAlignedRight();
    // R5 one-bit aligned sync, R6 right alignment, R3 inverted bit clock
    setFmt(3, 24, 20, 1, 32'hFFFF_FFFF);
    setSync(0, 0, 0, 1, 1);
    applyCfg();
    runCheck("R6", "R3", 3, 0);
  endtask

  task automatic testMono();
    // R8 single-slot mode
    setFmt(4, 16, 16, 0, 32'hFFFF_FFFF);
    setSync(1, 0, 0, 0, 0);
    applyCfg();
    runCheck("R8", "R5", 2, 0);
  endtask

  task automatic testUpperMask();
    // R7 upper mask half only: slots 17 and 19
    setFmt(20, 8, 8, 1, 32'h000A_0000);
    setSync(0, 0, 0, 0, 0);
    applyCfg();
    runCheck("R7", "R5", 2, 0);
  endtask

  task automatic testUnderrun();
    int t0;
    setFmt(2, 16, 16, 1, 32'hFFFF_FFFF);
    setSync(0, 0, 0, 0, 0);
    applyCfg();
    srcOn = 1'b0;
    t0 = takes;
    runCheck("R9", "R5", 1, 0);
    check("R9", "underrun after starved slots", underrun, 1);
    check("R11", "words taken while invalid", takes - t0, 0);
    repeat (5) @(negedge clk);
    check("R9", "underrun sticky", underrun, 1);
    srcOn = 1'b1;
    wr(2'd0, ctrlWord(0, 1));
    @(negedge clk);
    check("R9", "underrun cleared", underrun, 0);
    check("R3", "idle sdOut", sdOut, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1-all actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testDefaults();
    testWordSync();
    testOneBitEarly();
    testAlignedRight();
    testMono();
    testUpperMask();
    testUnderrun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule